// File: doc/BRIEF.md
# Complementary PWM Channel Pair with Deadtime

This block produces two pulse-width modulated outputs from a 16-bit up-counter that starts at a start value and wraps after a programmable top value. Each output is high while the counter sits inside a window bounded by two compare values. Because both edges are set independently, the same hardware gives edge-aligned, center-aligned, asymmetric and phase-shifted waveforms. In paired mode the second output is the inverse of the first. Each output then gets its own deadtime, which holds its rising edge back after the other output falls. In split mode the two outputs use their own windows and no deadtime is inserted.

Timing values are double buffered. Software presents them on shadow inputs, and the active copies change only at reload points. A reload point falls once every N counter wraps, with N from 1 to 16. An optional reload can also be taken at the counter midpoint. Per-output polarity inversion, a software override that takes effect on a force strobe, and filtered fault inputs sit in front of the registered output pins. A fault drives both pins to their safe levels.

Top module: `pwm_pair_top`

## Requirements
- R1: The counter runs from `init_val` up to the active top value and then returns to `init_val`, so one PWM cycle lasts (top - init + 1) clocks.
- R2: Before polarity, output A is high exactly while `a_on <= count < a_off`. Its high time per cycle therefore equals the number of counts in that window, wherever the window lies.
- R3: With `indep_mode` = 0, B before deadtime is the inverse of A. Each output's rising edge is delayed by its own deadtime count (`dt_a`, `dt_b`), which shortens its high time by that count. The two outputs are never high together.
- R4: In paired mode, a pulse whose length is not greater than that output's deadtime never appears at the output.
- R5: With `indep_mode` = 1, B is high exactly while `b_on <= count < b_off`. The deadtime counts have no effect on either output.
- R6: Shadow values on `sh_period` and the four compare inputs have no effect on the outputs until the next reload point.
- R7: A full reload is taken at the wrap of every (`reload_div` + 1)-th cycle, where field value 0 means every cycle and 15 means every 16th. `reload_pulse` is high for one clock after each reload point.
- R8: With `half_reload` = 1, a further reload is taken when the count equals init + (top - init)/2 (floor). This reload updates the compare values only; the top value changes only at full reloads.
- R9: `inv_a` and `inv_b` invert A and B independently, after deadtime.
- R10: Override bits and values (`sw_*_en`, `sw_*_val`) are captured only on a `force_evt` strobe. Both pins take their captured override values on the same clock, two clocks after the strobe is sampled. An output whose override bit is clear keeps its PWM waveform. Changing the override inputs without a strobe does nothing.
- R11: A fault input is accepted only after it has been high for `flt_len` consecutive clocks (a value of 0 acts as 1). A shorter pulse has no effect.
- R12: While a fault is accepted, A and B show `safe_a` and `safe_b`. After all faults clear, the pins stay at the safe levels until the next counter wrap and then resume normal operation.
- R13: While `rst` is high, `pwm_a`, `pwm_b` and `reload_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_val | input | CW | Counter start value |
| sh_period | input | CW | Shadow top value |
| sh_a_on | input | CW | Shadow rising compare, output A |
| sh_a_off | input | CW | Shadow falling compare, output A |
| sh_b_on | input | CW | Shadow rising compare, output B (split mode) |
| sh_b_off | input | CW | Shadow falling compare, output B (split mode) |
| reload_div | input | NW | Full reload every reload_div+1 cycles |
| half_reload | input | 1 | Adds a midpoint reload of the compares |
| indep_mode | input | 1 | 0 paired with deadtime, 1 split channels |
| dt_a | input | DTW | Deadtime count for A |
| dt_b | input | DTW | Deadtime count for B |
| inv_a | input | 1 | Invert A |
| inv_b | input | 1 | Invert B |
| sw_a_en | input | 1 | Override request for A |
| sw_b_en | input | 1 | Override request for B |
| sw_a_val | input | 1 | Override level for A |
| sw_b_val | input | 1 | Override level for B |
| force_evt | input | 1 | Strobe capturing the override inputs |
| fault_in | input | NF | Raw fault inputs, active high |
| flt_len | input | FW | Fault filter length in clocks |
| safe_a | input | 1 | Level of A while faulted |
| safe_b | input | 1 | Level of B while faulted |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| reload_pulse | output | 1 | One-clock pulse after each reload point |

## Verification
Nearly every internal fault in this block changes the high time counted over a whole number of PWM cycles. A wrong active compare, a wrong deadtime run length or a swapped buffer stage therefore shows as a wrong count within one cycle of the next reload. A wrong reload divider shows as a wrong number of reload pulses over a window of whole divider periods. A fault latch or override register that changes at the wrong moment shows at the pins within one or two clocks of the strobe, the fault edge or the following wrap. The bench times its samples against those events.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;
  typedef enum logic {
    MODE_PAIRED = 1'b0,
    MODE_SPLIT  = 1'b1
  } pair_mode_e;

  // index of each compare in the active compare bank
  localparam int IDX_A_ON  = 0;
  localparam int IDX_A_OFF = 1;
  localparam int IDX_B_ON  = 2;
  localparam int IDX_B_OFF = 3;
  localparam int NUM_CMP   = 4;
  localparam int NUM_OUT   = 2;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] sh_period,
  input  logic [NW-1:0] reload_div,
  input  logic          half_reload,
  output logic [CW-1:0] count,
  output logic          cmp_load,
  output logic          wrap
);
  logic [CW-1:0] cnt_q, top_q, mid;
  logic [NW-1:0] div_q;
  logic          start_q, at_top, full_ld, half_ld;

  assign at_top  = (cnt_q == top_q);
  assign mid     = init_val + ((top_q - init_val) >> 1);
  assign full_ld = at_top && (div_q == reload_div);
  assign half_ld = half_reload && (cnt_q == mid) && !start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      top_q   <= '0;
      div_q   <= '0;
      start_q <= 1'b1;
    end else if (start_q) begin
      cnt_q   <= init_val;
      top_q   <= sh_period;
      div_q   <= '0;
      start_q <= 1'b0;
    end else if (at_top) begin
      cnt_q <= init_val;
      div_q <= (div_q == reload_div) ? '0 : div_q + 1'b1;
      if (full_ld) top_q <= sh_period;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count    = cnt_q;
  assign cmp_load = start_q || full_ld || half_ld;
  assign wrap     = at_top && !start_q;
endmodule

// File: rtl/pwm_deadtime.sv
`timescale 1ns/1ps
module pwm_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raw,
  input  logic [DTW-1:0] dt,
  input  logic           bypass,
  output logic           gated
);
  // clocks the raw level has been high so far, saturating
  logic [DTW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !raw) run_q <= '0;
    else if (!(&run_q)) run_q <= run_q + 1'b1;
  end

  assign gated = bypass ? raw : (raw && (run_q >= dt));
endmodule

// File: rtl/pwm_fault_filter.sv
`timescale 1ns/1ps
module pwm_fault_filter #(
  parameter int NF = 4,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] fault_in,
  input  logic [FW-1:0] flt_len,
  input  logic          wrap,
  output logic          fault_act
);
  logic [NF-1:0] hit;

  for (genvar i = 0; i < NF; i++) begin : g_flt
    logic [FW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst || !fault_in[i]) run_q <= '0;
      else if (!(&run_q)) run_q <= run_q + 1'b1;
    end
    assign hit[i] = (run_q != '0) && (run_q >= flt_len);
  end

  always_ff @(posedge clk) begin
    if (rst)       fault_act <= 1'b0;
    else if (|hit) fault_act <= 1'b1;
    else if (wrap) fault_act <= 1'b0;
  end
endmodule

// File: rtl/pwm_pair_top.sv
`timescale 1ns/1ps
module pwm_pair_top
  import pwm_pair_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DTW = 8,
  parameter int NF  = 4,
  parameter int FW  = 4,
  parameter int NW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  init_val,
  input  logic [CW-1:0]  sh_period,
  input  logic [CW-1:0]  sh_a_on,
  input  logic [CW-1:0]  sh_a_off,
  input  logic [CW-1:0]  sh_b_on,
  input  logic [CW-1:0]  sh_b_off,
  input  logic [NW-1:0]  reload_div,
  input  logic           half_reload,
  input  logic           indep_mode,
  input  logic [DTW-1:0] dt_a,
  input  logic [DTW-1:0] dt_b,
  input  logic           inv_a,
  input  logic           inv_b,
  input  logic           sw_a_en,
  input  logic           sw_b_en,
  input  logic           sw_a_val,
  input  logic           sw_b_val,
  input  logic           force_evt,
  input  logic [NF-1:0]  fault_in,
  input  logic [FW-1:0]  flt_len,
  input  logic           safe_a,
  input  logic           safe_b,
  output logic           pwm_a,
  output logic           pwm_b,
  output logic           reload_pulse
);
  pair_mode_e    mode;
  logic [CW-1:0] count;
  logic          cmp_load, wrap, fault_act;
  logic [CW-1:0] cmp_sh [NUM_CMP];
  logic [CW-1:0] cmp_q  [NUM_CMP];
  logic          raw_a, raw_b, raw_b_own, gate_a, gate_b;
  logic [NUM_OUT-1:0] raw_v, gate_v;
  logic [DTW-1:0] dt_v [NUM_OUT];
  logic          frc_en_a, frc_en_b, frc_v_a, frc_v_b;

  assign mode = pair_mode_e'(indep_mode);

  pwm_timebase #(.CW(CW), .NW(NW)) u_tb (
    .clk(clk), .rst(rst), .init_val(init_val), .sh_period(sh_period),
    .reload_div(reload_div), .half_reload(half_reload),
    .count(count), .cmp_load(cmp_load), .wrap(wrap)
  );

  assign cmp_sh[IDX_A_ON]  = sh_a_on;
  assign cmp_sh[IDX_A_OFF] = sh_a_off;
  assign cmp_sh[IDX_B_ON]  = sh_b_on;
  assign cmp_sh[IDX_B_OFF] = sh_b_off;

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_CMP; k++) begin
      if (rst)           cmp_q[k] <= '0;
      else if (cmp_load) cmp_q[k] <= cmp_sh[k];
    end
  end

  assign raw_a     = (count >= cmp_q[IDX_A_ON]) && (count < cmp_q[IDX_A_OFF]);
  assign raw_b_own = (count >= cmp_q[IDX_B_ON]) && (count < cmp_q[IDX_B_OFF]);
  assign raw_b     = (mode == MODE_SPLIT) ? raw_b_own : !raw_a;

  assign raw_v   = {raw_b, raw_a};
  assign dt_v[0] = dt_a;
  assign dt_v[1] = dt_b;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_dt
    pwm_deadtime #(.DTW(DTW)) u_dt (
      .clk(clk), .rst(rst), .raw(raw_v[g]), .dt(dt_v[g]),
      .bypass(mode == MODE_SPLIT), .gated(gate_v[g])
    );
  end

  assign gate_a = gate_v[0];
  assign gate_b = gate_v[1];

  pwm_fault_filter #(.NF(NF), .FW(FW)) u_flt (
    .clk(clk), .rst(rst), .fault_in(fault_in), .flt_len(flt_len),
    .wrap(wrap), .fault_act(fault_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frc_en_a <= 1'b0; frc_en_b <= 1'b0;
      frc_v_a  <= 1'b0; frc_v_b  <= 1'b0;
    end else if (force_evt) begin
      frc_en_a <= sw_a_en;  frc_en_b <= sw_b_en;
      frc_v_a  <= sw_a_val; frc_v_b  <= sw_b_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_a        <= 1'b0;
      pwm_b        <= 1'b0;
      reload_pulse <= 1'b0;
    end else begin
      reload_pulse <= cmp_load;
      pwm_a <= fault_act ? safe_a : (frc_en_a ? frc_v_a : (gate_a ^ inv_a));
      pwm_b <= fault_act ? safe_b : (frc_en_b ? frc_v_b : (gate_b ^ inv_b));
    end
  end
endmodule

// File: rtl/pwm_pair_chk.sv
`timescale 1ns/1ps
module pwm_pair_chk #(
  parameter int NF  = 4,
  parameter int DTW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           indep_mode,
  input logic [DTW-1:0] dt_a,
  input logic           raw_a,
  input logic           gate_a,
  input logic           gate_b,
  input logic           fault_act,
  input logic [NF-1:0]  fault_in,
  input logic           safe_a,
  input logic           safe_b,
  input logic           pwm_a,
  input logic           pwm_b,
  input logic           frc_en_a,
  input logic           frc_v_a
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !indep_mode |-> !(gate_a && gate_b));

  assert_dt_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && dt_a != '0 && gate_a) |-> $past(raw_a));

  assert_short_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && dt_a != '0 && $rose(raw_a)) |-> !gate_a);

  assert_force_value_R10: assert property (@(posedge clk) disable iff (rst)
    (!fault_act && frc_en_a) |=> (pwm_a == $past(frc_v_a)));

  assert_fault_filtered_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_act) |-> $past(|fault_in, 2));

  assert_safe_level_R12: assert property (@(posedge clk) disable iff (rst)
    fault_act |=> (pwm_a == $past(safe_a) && pwm_b == $past(safe_b)));
endmodule

bind pwm_pair_top pwm_pair_chk #(.NF(NF), .DTW(DTW)) u_chk (
  .clk(clk), .rst(rst), .indep_mode(indep_mode), .dt_a(dt_a),
  .raw_a(raw_a), .gate_a(gate_a), .gate_b(gate_b), .fault_act(fault_act),
  .fault_in(fault_in), .safe_a(safe_a), .safe_b(safe_b),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .frc_en_a(frc_en_a), .frc_v_a(frc_v_a)
);

// File: tb/tb_pwm_pair_top.sv
`timescale 1ns/1ps
module tb_pwm_pair_top;
  localparam int CW = 16, DTW = 8, NF = 4, FW = 4, NW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] init_val, sh_period, sh_a_on, sh_a_off, sh_b_on, sh_b_off;
  logic [NW-1:0] reload_div;
  logic half_reload, indep_mode, inv_a, inv_b;
  logic [DTW-1:0] dt_a, dt_b;
  logic sw_a_en, sw_b_en, sw_a_val, sw_b_val, force_evt;
  logic [NF-1:0] fault_in;
  logic [FW-1:0] flt_len;
  logic safe_a, safe_b;
  logic pwm_a, pwm_b, reload_pulse;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  pwm_pair_top #(.CW(CW), .DTW(DTW), .NF(NF), .FW(FW), .NW(NW)) dut (
    .clk(clk), .rst(rst), .init_val(init_val), .sh_period(sh_period),
    .sh_a_on(sh_a_on), .sh_a_off(sh_a_off), .sh_b_on(sh_b_on), .sh_b_off(sh_b_off),
    .reload_div(reload_div), .half_reload(half_reload), .indep_mode(indep_mode),
    .dt_a(dt_a), .dt_b(dt_b), .inv_a(inv_a), .inv_b(inv_b),
    .sw_a_en(sw_a_en), .sw_b_en(sw_b_en), .sw_a_val(sw_a_val), .sw_b_val(sw_b_val),
    .force_evt(force_evt), .fault_in(fault_in), .flt_len(flt_len),
    .safe_a(safe_a), .safe_b(safe_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .reload_pulse(reload_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(input int n, output int ca, output int cb, output int cab, output int cr);
    ca = 0; cb = 0; cab = 0; cr = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca  += int'(pwm_a);
      cb  += int'(pwm_b);
      cab += int'(pwm_a && pwm_b);
      cr  += int'(reload_pulse);
    end
  endtask

  task automatic wait_reload();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (reload_pulse) break;
    end
  endtask

  task automatic base_cfg();
    init_val = 0; sh_period = 9; sh_a_on = 2; sh_a_off = 7; sh_b_on = 0; sh_b_off = 3;
    reload_div = 0; half_reload = 0; indep_mode = 0; dt_a = 0; dt_b = 0;
    inv_a = 0; inv_b = 0; sw_a_en = 0; sw_b_en = 0; sw_a_val = 0; sw_b_val = 0;
    force_evt = 0; fault_in = '0; flt_len = 3; safe_a = 1; safe_b = 0;
  endtask

  task automatic t_reset();
    tick(3);
    chk("R13 pwm_a in reset", int'(pwm_a), 0);
    chk("R13 pwm_b in reset", int'(pwm_b), 0);
    chk("R13 reload_pulse in reset", int'(reload_pulse), 0);
    rst = 1'b0;
    tick(30);
  endtask

  task automatic t_period();
    int ca, cb, cab, cr;
    meas(100, ca, cb, cab, cr);
    chk("R1 reloads per 100 clk, period 10", cr, 10);
    chk("R2 A high, window 2..6", ca, 50);
    chk("R3 B inverse width", cb, 50);
    init_val = 5; sh_period = 24;
    tick(50);
    meas(100, ca, cb, cab, cr);
    chk("R1 reloads per 100 clk, period 20", cr, 5);
    chk("R2 A high with init 5", ca, 10);
    base_cfg(); tick(50);
  endtask

  task automatic t_asym();
    int ca, cb, cab, cr;
    sh_a_on = 6; sh_a_off = 9; tick(30);
    meas(100, ca, cb, cab, cr);
    chk("R2 shifted window A", ca, 30);
    chk("R3 B complement of shifted A", cb, 70);
    base_cfg(); tick(30);
  endtask

  task automatic t_deadtime();
    int ca, cb, cab, cr;
    dt_a = 1; dt_b = 2; tick(30);
    meas(100, ca, cb, cab, cr);
    chk("R3 A shortened by dt_a", ca, 40);
    chk("R3 B shortened by dt_b", cb, 30);
    chk("R3 no overlap", cab, 0);
    sh_a_off = 4; dt_a = 3; dt_b = 0; tick(30);
    meas(100, ca, cb, cab, cr);
    chk("R4 short A pulse suppressed", ca, 0);
    chk("R4 B unaffected", cb, 80);
    base_cfg(); tick(30);
  endtask

  task automatic t_split();
    int ca, cb, cab, cr;
    indep_mode = 1; dt_a = 5; dt_b = 5; tick(30);
    meas(100, ca, cb, cab, cr);
    chk("R5 A in split mode", ca, 50);
    chk("R5 B own window", cb, 30);
    chk("R5 overlap allowed", cab, 10);
    base_cfg(); tick(30);
  endtask

  task automatic t_polarity();
    int ca, cb, cab, cr;
    sh_a_off = 8; inv_a = 1; tick(30);
    meas(100, ca, cb, cab, cr);
    chk("R9 A inverted", ca, 40);
    chk("R9 B not inverted", cb, 40);
    inv_b = 1; tick(5);
    meas(100, ca, cb, cab, cr);
    chk("R9 B inverted", cb, 60);
    base_cfg(); tick(30);
  endtask

  task automatic t_reload_rate();
    int ca, cb, cab, cr;
    reload_div = 3; tick(50);
    meas(200, ca, cb, cab, cr);
    chk("R7 reloads with N=4", cr, 5);
    half_reload = 1; tick(50);
    meas(200, ca, cb, cab, cr);
    chk("R8 reloads with N=4 plus midpoint", cr, 25);
    base_cfg(); tick(50);
  endtask

  task automatic t_double_buffer();
    int ca, cb, cab, cr;
    reload_div = 15; tick(200);
    wait_reload();
    sh_a_off = 4;
    tick(10);
    meas(100, ca, cb, cab, cr);
    chk("R6 shadow not yet active", ca, 50);
    wait_reload();
    tick(10);
    meas(100, ca, cb, cab, cr);
    chk("R6 shadow active after reload", ca, 20);
    base_cfg(); tick(200);
  endtask

  task automatic t_force();
    int ca, cb, cab, cr;
    sh_a_on = 0; sh_a_off = 0; tick(30);
    sw_a_en = 1; sw_a_val = 1; tick(5);
    chk("R10 override ignored without strobe", int'(pwm_a), 0);
    sw_b_en = 1; sw_b_val = 0; force_evt = 1;
    tick(1); force_evt = 0;
    chk("R10 A one clk after strobe", int'(pwm_a), 0);
    chk("R10 B one clk after strobe", int'(pwm_b), 1);
    tick(1);
    chk("R10 A forced", int'(pwm_a), 1);
    chk("R10 B forced same clk", int'(pwm_b), 0);
    sh_a_on = 2; sh_a_off = 7; sw_b_en = 0; force_evt = 1;
    tick(1); force_evt = 0;
    tick(30);
    meas(100, ca, cb, cab, cr);
    chk("R10 A held by override", ca, 100);
    chk("R10 B keeps waveform", cb, 50);
    base_cfg(); force_evt = 1; tick(1); force_evt = 0; tick(30);
  endtask

  task automatic t_fault();
    int ca, cb, cab, cr, nsafe;
    sh_a_on = 0; sh_a_off = 0; tick(30);
    fault_in[0] = 1; tick(2); fault_in[0] = 0;
    meas(20, ca, cb, cab, cr);
    chk("R11 short fault rejected", ca, 0);
    fault_in[1] = 1; tick(8);
    chk("R12 A safe level", int'(pwm_a), 1);
    chk("R12 B safe level", int'(pwm_b), 0);
    wait_reload();
    fault_in[1] = 0;
    nsafe = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      nsafe += int'(pwm_a && !pwm_b);
    end
    chk("R12 safe held until wrap", nsafe, 8);
    tick(12);
    chk("R12 A recovered", int'(pwm_a), 0);
    chk("R12 B recovered", int'(pwm_b), 1);
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    base_cfg();
    t_reset();
    t_period();
    t_asym();
    t_deadtime();
    t_split();
    t_polarity();
    t_reload_rate();
    t_double_buffer();
    t_force();
    t_fault();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule